// File: doc/BRIEF.md
# Comparator Interrupt and Input Select Controller

This block is the digital control shell that sits beside an analog voltage comparator. It receives the comparator's result, already synchronized to the system clock. From one byte-wide control/status register it drives the selects that choose what reaches each comparator input. It also drives a power-off line, and it raises an interrupt when the comparator result moves in the direction that software has chosen.

The negative input can be taken either from a dedicated pin or from the converter's input multiplexer. The multiplexer is used only when a mux-enable request is present and the converter itself is switched off. The positive input is either a pin or an internal reference. The block registers the compare result into a read-only status bit. Edges of that bit set a sticky flag, and software clears the flag by writing one to it. The interrupt line is the flag qualified by an enable. Setting the power-off bit forces the status bit low. A result that was high at that moment therefore produces a falling edge, which can raise an unwanted event if the enable is still set.

Top module: `acmp_ctrl`

## Requirements
- R1: After reset every writable register bit is 0, so `reg_rdata` reads 0x00 while `cmp_in` is 0, and `irq`, `pos_sel_ref` and `cmp_pwr_off` are 0.
- R2: Status bit 5 follows `cmp_in` one clock later (1 means the positive input is above the negative input). At every edge where power-off bit 7 was already 1, status bit 5 is loaded with 0 instead.
- R3: `neg_sel_mux` is 1 exactly when `mux_en` is 1 and `conv_en` is 0. In every other case it is 0, which selects the dedicated negative pin.
- R4: `pos_sel_ref` equals register bit 6 (1 = internal reference drives the positive input, 0 = positive pin).
- R5: Edge mode field bits 1:0 selects the event. 00 is any change of status bit 5, 10 is its 1-to-0 change and 11 is its 0-to-1 change. An event sets flag bit 4 on the same edge at which bit 5 changes.
- R6: Edge mode 01 is reserved and never sets the flag, whatever `cmp_in` does.
- R7: The flag is set by an event whether or not enable bit 3 is set. `irq` is 1 exactly when both bit 4 and bit 3 are 1.
- R8: A write with bit 4 = 1 clears the flag, and a write with bit 4 = 0 leaves it unchanged. If an event and a clearing write fall on the same edge, the flag ends up set.
- R9: Writes store bits 7, 6, 3 and 1:0 only. Bit 5 is not writable, and bit 2 always reads 0.
- R10: `cmp_pwr_off` equals bit 7. Setting bit 7 while status bit 5 is 1 yields a falling edge of bit 5, which counts as an event in modes 00 and 10. While bit 7 stays 1 no further event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Synchronized comparator result |
| conv_en | input | 1 | Converter powered on |
| mux_en | input | 1 | Request to route the converter multiplexer to the negative input |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read value |
| neg_sel_mux | output | 1 | Negative input from the converter multiplexer (0 = dedicated pin) |
| pos_sel_ref | output | 1 | Positive input from the internal reference (0 = pin) |
| cmp_pwr_off | output | 1 | Comparator power-down |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets four corner cases:
- Setting the power-off bit while the result is high must produce exactly one falling-edge event and then stay quiet. A design that gated edge detection by the disable bit would miss that event, and one that passed `cmp_in` through while off would keep raising events.
- A clear write that lands on the same edge as a new event must leave the flag set. A design with the opposite priority would lose that interrupt.
- Each edge mode is driven against the wrong-direction edge, and the reserved mode against a toggling input, to catch a misdecoded mode field.
- All four combinations of the routing inputs are applied, which exposes a select that ignores the converter-enable term.

// File: rtl/acmp_pkg.sv
package acmp_pkg;

    typedef enum logic [1:0] {
        EDGE_ANY  = 2'b00,
        EDGE_NONE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_RISE = 2'b11
    } edge_mode_e;

    // Bit positions inside the control/status byte; software decodes these.
    localparam int unsigned POS_OFF   = 7;
    localparam int unsigned POS_REF   = 6;
    localparam int unsigned POS_OUT   = 5;
    localparam int unsigned POS_FLAG  = 4;
    localparam int unsigned POS_IE    = 3;
    localparam int unsigned POS_ZERO  = 2;
    localparam int unsigned POS_MODE  = 0;
    localparam int unsigned MODE_W    = 2;
    localparam int unsigned MIN_REG_W = 8;

    typedef struct packed {
        logic       off;
        logic       ref_sel;
        logic       out;
        logic       flag;
        logic       ie;
        edge_mode_e mode;
    } ctl_s;

endpackage

// File: rtl/acmp_edge_det.sv
module acmp_edge_det
    import acmp_pkg::*;
(
    input  logic       prev_i,
    input  logic       next_i,
    input  edge_mode_e mode_i,
    output logic       hit_o
);

    logic rise;
    logic fall;

    always_comb begin
        rise = ~prev_i & next_i;
        fall = prev_i & ~next_i;
        unique case (mode_i)
            EDGE_ANY:  hit_o = rise | fall;
            EDGE_FALL: hit_o = fall;
            EDGE_RISE: hit_o = rise;
            default:   hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/acmp_route.sv
module acmp_route (
    input  logic mux_en_i,
    input  logic conv_en_i,
    input  logic ref_sel_i,
    output logic neg_mux_o,
    output logic pos_ref_o
);

    always_comb begin
        neg_mux_o = mux_en_i & ~conv_en_i;
        pos_ref_o = ref_sel_i;
    end

endmodule

// File: rtl/acmp_ctrl.sv
module acmp_ctrl
    import acmp_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_in,
    input  logic             conv_en,
    input  logic             mux_en,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             neg_sel_mux,
    output logic             pos_sel_ref,
    output logic             cmp_pwr_off,
    output logic             irq
);

    localparam int unsigned MODE_HI = POS_MODE + MODE_W - 1;

    initial begin
        if (REG_W < MIN_REG_W) $error("acmp_ctrl: REG_W too small");
    end

    ctl_s st_d;
    ctl_s st_q;
    logic out_next;
    logic edge_hit;
    logic flag_clr;

    acmp_edge_det u_edge (
        .prev_i (st_q.out),
        .next_i (out_next),
        .mode_i (st_q.mode),
        .hit_o  (edge_hit)
    );

    acmp_route u_route (
        .mux_en_i  (mux_en),
        .conv_en_i (conv_en),
        .ref_sel_i (st_q.ref_sel),
        .neg_mux_o (neg_sel_mux),
        .pos_ref_o (pos_sel_ref)
    );

    always_comb begin
        st_d     = st_q;
        out_next = st_q.off ? 1'b0 : cmp_in;
        flag_clr = reg_wr & reg_wdata[POS_FLAG];
        st_d.out  = out_next;
        st_d.flag = (st_q.flag & ~flag_clr) | edge_hit;
        if (reg_wr) begin
            st_d.off     = reg_wdata[POS_OFF];
            st_d.ref_sel = reg_wdata[POS_REF];
            st_d.ie      = reg_wdata[POS_IE];
            st_d.mode    = edge_mode_e'(reg_wdata[MODE_HI:POS_MODE]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{off: 1'b0, ref_sel: 1'b0, out: 1'b0, flag: 1'b0,
                      ie: 1'b0, mode: EDGE_ANY};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata                   = '0;
        reg_rdata[POS_OFF]          = st_q.off;
        reg_rdata[POS_REF]          = st_q.ref_sel;
        reg_rdata[POS_OUT]          = st_q.out;
        reg_rdata[POS_FLAG]         = st_q.flag;
        reg_rdata[POS_IE]           = st_q.ie;
        reg_rdata[POS_ZERO]         = 1'b0;
        reg_rdata[MODE_HI:POS_MODE] = st_q.mode;
        cmp_pwr_off                 = st_q.off;
        irq                         = st_q.flag & st_q.ie;
    end

endmodule

// File: rtl/acmp_ctrl_chk.sv
module acmp_ctrl_chk #(
    parameter int unsigned REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_en,
    input logic             mux_en,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             neg_sel_mux,
    input logic             cmp_pwr_off,
    input logic             irq
);

    a_r2_off_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_pwr_off |=> !reg_rdata[5]);

    a_r3_mux_only_when_conv_off: assert property (@(posedge clk) disable iff (!rst_n)
        neg_sel_mux |-> (mux_en && !conv_en));

    a_r5_rise_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1:0] == 2'b11 && !reg_rdata[5]) ##1 reg_rdata[5] |-> reg_rdata[4]);

    a_r6_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1:0] == 2'b01 && !reg_rdata[4]) |=> !reg_rdata[4]);

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> reg_rdata[3]);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[4] && !(reg_wr && reg_wdata[4])) |=> reg_rdata[4]);

    a_r10_off_spurious_event: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7] && reg_rdata[5] && reg_rdata[1:0] == 2'b00) |=> reg_rdata[4]);

endmodule

bind acmp_ctrl acmp_ctrl_chk #(.REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_en     (conv_en),
    .mux_en      (mux_en),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .neg_sel_mux (neg_sel_mux),
    .cmp_pwr_off (cmp_pwr_off),
    .irq         (irq)
);

// File: tb/tb_acmp_ctrl.sv
module tb_acmp_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_in = 1'b0;
    logic       conv_en = 1'b0;
    logic       mux_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       neg_sel_mux;
    logic       pos_sel_ref;
    logic       cmp_pwr_off;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    acmp_ctrl #(.REG_W(8)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_in      (cmp_in),
        .conv_en     (conv_en),
        .mux_en      (mux_en),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .neg_sel_mux (neg_sel_mux),
        .pos_sel_ref (pos_sel_ref),
        .cmp_pwr_off (cmp_pwr_off),
        .irq         (irq)
    );

    // Behavioural reference model
    bit m_off = 0, m_ref = 0, m_out = 0, m_flag = 0, m_ie = 0;
    int m_mode = 0;

    always @(posedge clk) begin
        bit nout;
        bit ev;
        if (!rst_n) begin
            m_off = 0; m_ref = 0; m_out = 0; m_flag = 0; m_ie = 0; m_mode = 0;
        end else begin
            nout = m_off ? 1'b0 : cmp_in;
            ev = (m_mode == 0 && nout != m_out) ||
                 (m_mode == 2 && m_out && !nout) ||
                 (m_mode == 3 && !m_out && nout);
            m_flag = (m_flag && !(reg_wr && reg_wdata[4])) || ev;
            if (reg_wr) begin
                m_off  = reg_wdata[7];
                m_ref  = reg_wdata[6];
                m_ie   = reg_wdata[3];
                m_mode = int'(reg_wdata[1:0]);
            end
            m_out = nout;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(reg_rdata[5] == m_out, "R2 status bit", reg_rdata[5], m_out);
            chk(reg_rdata[4] == m_flag, "R5 flag", reg_rdata[4], m_flag);
            chk(irq == (m_flag && m_ie), "R7 irq", irq, m_flag && m_ie);
            chk(neg_sel_mux == (mux_en && !conv_en), "R3 neg select", neg_sel_mux, mux_en && !conv_en);
            chk(pos_sel_ref == m_ref, "R4 pos select", pos_sel_ref, m_ref);
            chk(cmp_pwr_off == m_off, "R10 power off", cmp_pwr_off, m_off);
            chk({reg_rdata[7:6], reg_rdata[3:0]} == {m_off, m_ref, m_ie, 1'b0, 2'(m_mode)},
                "R9 stored bits", {reg_rdata[7:6], reg_rdata[3:0]},
                {m_off, m_ref, m_ie, 1'b0, 2'(m_mode)});
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
        reg_wdata = 8'h00;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(reg_rdata == 8'h00, "R1 reset rdata", reg_rdata, 0);
        chk(irq == 1'b0 && pos_sel_ref == 1'b0 && cmp_pwr_off == 1'b0, "R1 reset outputs",
            {irq, pos_sel_ref, cmp_pwr_off}, 0);

        // R5 toggle mode with enable
        wr(8'h08);
        cmp_in = 1'b1;
        tick(1);
        chk(reg_rdata[5] == 1'b1, "R2 follows input", reg_rdata[5], 1);
        chk(reg_rdata[4] == 1'b1 && irq, "R5 toggle event", {reg_rdata[4], irq}, 3);
        // R8 clear
        wr(8'h18);
        chk(reg_rdata[4] == 1'b0, "R8 clear by one", reg_rdata[4], 0);

        // R5 falling mode
        wr(8'h0A);
        cmp_in = 1'b0;
        tick(1);
        chk(reg_rdata[4] == 1'b1, "R5 falling event", reg_rdata[4], 1);
        wr(8'h0A);
        chk(reg_rdata[4] == 1'b1, "R8 write zero keeps flag", reg_rdata[4], 1);
        wr(8'h1A);
        cmp_in = 1'b1;
        tick(2);
        chk(reg_rdata[4] == 1'b0, "R5 rise ignored in fall mode", reg_rdata[4], 0);

        // R5 rising mode, R7 flag without enable
        wr(8'h13);
        cmp_in = 1'b0;
        tick(2);
        chk(reg_rdata[4] == 1'b0, "R5 fall ignored in rise mode", reg_rdata[4], 0);
        cmp_in = 1'b1;
        tick(1);
        chk(reg_rdata[4] == 1'b1 && !irq, "R7 flag without enable", {reg_rdata[4], irq}, 2);

        // R6 reserved mode
        wr(8'h19);
        for (int i = 0; i < 6; i++) begin
            cmp_in = ~cmp_in;
            tick(1);
        end
        chk(reg_rdata[4] == 1'b0, "R6 reserved mode quiet", reg_rdata[4], 0);

        // R9 read-only bits
        cmp_in = 1'b0;
        tick(2);
        wr(8'h25);
        chk(reg_rdata[5] == 1'b0 && reg_rdata[2] == 1'b0, "R9 read-only bits",
            {reg_rdata[5], reg_rdata[2]}, 0);

        // R3 / R4 routing
        for (int c = 0; c < 4; c++) begin
            mux_en = c[0];
            conv_en = c[1];
            #1;
            chk(neg_sel_mux == (c == 1), "R3 routing combo", neg_sel_mux, c == 1);
        end
        tick(1);
        wr(8'h41);
        chk(pos_sel_ref == 1'b1, "R4 reference select", pos_sel_ref, 1);
        wr(8'h01);
        chk(pos_sel_ref == 1'b0, "R4 pin select", pos_sel_ref, 0);

        // R8 set wins over clear on the same edge
        wr(8'h08);
        tick(1);
        reg_wr = 1'b1;
        reg_wdata = 8'h18;
        cmp_in = ~cmp_in;
        tick(1);
        reg_wr = 1'b0;
        reg_wdata = 8'h00;
        chk(reg_rdata[4] == 1'b1, "R8 set beats clear", reg_rdata[4], 1);

        // R10 spurious event on disable
        wr(8'h1A);
        cmp_in = 1'b1;
        tick(2);
        wr(8'h1A);
        chk(reg_rdata[4] == 1'b0 && reg_rdata[5] == 1'b1, "R10 setup",
            {reg_rdata[4], reg_rdata[5]}, 1);
        wr(8'h8A);
        chk(cmp_pwr_off == 1'b1, "R10 power off output", cmp_pwr_off, 1);
        tick(1);
        chk(reg_rdata[5] == 1'b0, "R2 low while off", reg_rdata[5], 0);
        chk(reg_rdata[4] == 1'b1 && irq, "R10 spurious falling event", {reg_rdata[4], irq}, 3);
        wr(8'h98);
        for (int i = 0; i < 5; i++) begin
            cmp_in = ~cmp_in;
            tick(1);
        end
        chk(reg_rdata[4] == 1'b0 && reg_rdata[5] == 1'b0, "R10 quiet while off",
            {reg_rdata[4], reg_rdata[5]}, 0);

        tick(2);
        finish_run();
    end

endmodule